// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is the datapath and control of a small single-cycle processor with 16-bit words. Every clock cycle it takes one instruction word from an external program memory at the address shown on its program counter output. It has two working registers: an address register, which also supplies the data-memory address, and a data register, which is always the first ALU operand. Program memory and data memory both stay outside the block.

There are two instruction formats. If the top bit is clear, the word is an immediate: its low 15 bits are loaded into the address register. If the top bit is set, the word is a compute instruction. In a compute word, one bit picks the second ALU operand: either the address register or the word read from memory. Six bits drive an ALU that can clear and invert each operand, either add or AND the two, and then invert the result. Three bits pick which of the address register, the data register and memory receive the result. Three more bits form a jump mask, tested against the sign and zero of the result.

The address register, the data register and the program counter all update on the same rising edge. A jump loads the program counter with the address-register value from before that edge. The memory write strobe is combinational, so the external RAM samples it on the same edge.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, the address register and the data register all become 0 at that edge. Reset takes precedence over any jump.
- R2: A word with bit 15 = 0 loads `{0, instr[14:0]}` into the address register, so it shows on `mem_addr` after the edge. It never asserts `mem_we` and leaves the data register unchanged.
- R3: In a compute word (bit 15 = 1), bits 14 and 13 have no effect on the result, on the destinations or on the jump.
- R4: Bit 12 of a compute word picks the second ALU operand: the address register when it is 0, and `mem_rdata` when it is 1. The first operand is always the data register.
- R5: Bits 11..6 drive, from high to low: clear operand 1, invert operand 1, clear operand 2, invert operand 2, function select (1 = add, 0 = bitwise AND), and invert result. `mem_wdata` carries the ALU result.
- R6: Bit 5 writes the result to the address register, bit 4 to the data register, and bit 3 asserts `mem_wdata` onto memory through `mem_we`. Any combination of the three is allowed. A register not selected keeps its value.
- R7: Bit 2 enables a jump when the result is negative (bit 15 set). Bit 1 enables it when the result is zero. Bit 0 enables it when the result is positive, meaning neither negative nor zero. A taken jump loads the program counter with the address register's value from before the edge.
- R8: When there is no reset and no jump, the program counter increases by 1, wrapping from 0x7FFF to 0.
- R9: `mem_addr` and the jump target both use the address register's value from before the edge, even when the same instruction also writes the address register.
- R10: A loop program that sums the counts 10 down to 1 into memory ends with 55 in the sum word and 0 in the counter word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word fetched at `pc` |
| mem_rdata | input | 16 | Data memory word at `mem_addr` |
| mem_wdata | output | 16 | ALU result, the data to store |
| mem_we | output | 1 | Memory write strobe for the current instruction |
| mem_addr | output | 15 | Data memory address (address register) |
| pc | output | 15 | Program counter, the address of the next instruction |

## Verification
The case most likely to break the core is an address-register write and a jump in the same instruction. Both read the address register, and only the old value may be used. The bench runs a word that increments the address register and jumps unconditionally. It then checks that the program counter lands on the old value while `mem_addr` already shows the new one, and that the instruction at the target stores to the new address. A related case is a combined write of all three destinations: the memory store must go to the address held before the edge, while the register takes the result.

// File: rtl/acc_core_pkg.sv
`timescale 1ns/1ps
package acc_core_pkg;

  typedef struct packed {
    logic clr_x;
    logic inv_x;
    logic clr_y;
    logic inv_y;
    logic use_add;
    logic inv_out;
  } alu_ctrl_t;

  typedef struct packed {
    logic      is_comp;
    logic      sel_mem;
    alu_ctrl_t alu;
    logic      wr_a;
    logic      wr_d;
    logic      wr_m;
    logic [2:0] jmask;
  } dec_t;

  localparam int unsigned SEL_BIT  = 12;
  localparam int unsigned ALU_LSB  = 6;
  localparam int unsigned DST_LSB  = 3;
  localparam int unsigned JMP_LSB  = 0;

endpackage

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
  import acc_core_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] instr,
  output dec_t         dec
);
  logic unused_pad;
  assign unused_pad = ^instr[W-2:W-3];

  always_comb begin
    dec.is_comp = instr[W-1];
    dec.sel_mem = instr[SEL_BIT];
    dec.alu     = alu_ctrl_t'(instr[ALU_LSB +: 6]);
    dec.wr_a    = instr[DST_LSB + 2];
    dec.wr_d    = instr[DST_LSB + 1];
    dec.wr_m    = instr[DST_LSB];
    dec.jmask   = instr[JMP_LSB +: 3];
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_ctrl_t    ctl,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  logic [W-1:0] x0, x1, y0, y1, raw;

  always_comb begin
    x0  = ctl.clr_x ? '0 : x;
    x1  = ctl.inv_x ? ~x0 : x0;
    y0  = ctl.clr_y ? '0 : y;
    y1  = ctl.inv_y ? ~y0 : y0;
    raw = ctl.use_add ? (x1 + y1) : (x1 & y1);
    res = ctl.inv_out ? ~raw : raw;
  end

  assign is_zero = (res == '0);
  assign is_neg  = res[W-1];
endmodule

// File: rtl/acc_branch.sv
`timescale 1ns/1ps
module acc_branch (
  input  logic       is_comp,
  input  logic [2:0] jmask,
  input  logic       is_zero,
  input  logic       is_neg,
  output logic       take
);
  logic is_pos;
  assign is_pos = !is_zero && !is_neg;
  assign take   = is_comp && ((jmask[2] && is_neg) ||
                              (jmask[1] && is_zero) ||
                              (jmask[0] && is_pos));
endmodule

// File: rtl/acc_pc.sv
`timescale 1ns/1ps
module acc_pc #(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (take) pc <= target;
    else           pc <= pc + 1'b1;
  end

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0)
    else $error("pc not cleared by reset");

  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> pc == $past(target))
    else $error("jump did not load target");

  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == $past(pc) + 1'b1)
    else $error("pc did not step");
endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core
  import acc_core_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   instr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [DATA_W-2:0]   mem_addr,
  output logic [DATA_W-2:0]   pc
);
  localparam int unsigned PC_W = DATA_W - 1;

  dec_t              dec;
  logic [DATA_W-1:0] a_q, d_q, y_op, alu_res;
  logic              alu_zero, alu_neg, take;

  acc_decode #(.W(DATA_W)) u_dec (.instr(instr), .dec(dec));

  assign y_op = dec.sel_mem ? mem_rdata : a_q;

  acc_alu #(.W(DATA_W)) u_alu (
    .x(d_q), .y(y_op), .ctl(dec.alu),
    .res(alu_res), .is_zero(alu_zero), .is_neg(alu_neg)
  );

  acc_branch u_br (
    .is_comp(dec.is_comp), .jmask(dec.jmask),
    .is_zero(alu_zero), .is_neg(alu_neg), .take(take)
  );

  acc_pc #(.AW(PC_W)) u_pc (
    .clk(clk), .rst(rst), .take(take), .target(a_q[PC_W-1:0]), .pc(pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      d_q <= '0;
    end else begin
      if (!dec.is_comp)  a_q <= {1'b0, instr[PC_W-1:0]};
      else if (dec.wr_a) a_q <= alu_res;
      if (dec.is_comp && dec.wr_d) d_q <= alu_res;
    end
  end

  assign mem_wdata = alu_res;
  assign mem_we    = dec.is_comp && dec.wr_m;
  assign mem_addr  = a_q[PC_W-1:0];

  p_imm_load_r2: assert property (@(posedge clk) disable iff (rst)
    !instr[DATA_W-1] |=> mem_addr == $past(instr[PC_W-1:0]))
    else $error("immediate not loaded");

  p_d_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(instr[DATA_W-1] && instr[4]) |=> $stable(d_q))
    else $error("data register changed without select");

  p_a_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (instr[DATA_W-1] && !instr[5]) |=> $stable(a_q))
    else $error("address register changed without select");

  always_comb begin
    if (!rst && !instr[DATA_W-1])
      p_imm_nowrite_r2: assert (!mem_we) else $error("write on immediate");
  end
endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr, mem_rdata, mem_wdata;
  logic        mem_we;
  logic [14:0] mem_addr, pc;

  logic [15:0] rom [64];
  logic [15:0] ram [256];
  logic        clr_req = 1'b0, poke_req = 1'b0;
  logic [7:0]  poke_a = '0;
  logic [15:0] poke_d = '0;
  int checks = 0, errors = 0;

  localparam logic [5:0] K_ZERO = 6'b101010, K_ONE = 6'b111111, K_M1 = 6'b111010,
    K_D = 6'b001100, K_A = 6'b110000, K_ND = 6'b001101, K_NEGD = 6'b001111,
    K_DP1 = 6'b011111, K_AP1 = 6'b110111, K_AM1 = 6'b110010, K_DM1 = 6'b001110,
    K_DPA = 6'b000010, K_DMA = 6'b010011, K_AMD = 6'b000111, K_AND = 6'b000000,
    K_OR = 6'b010101;

  always #2 clk = ~clk;

  assign instr     = rom[pc[5:0]];
  assign mem_rdata = ram[mem_addr[7:0]];

  always @(posedge clk) begin
    if (clr_req) for (int i = 0; i < 256; i++) ram[i] <= '0;
    else if (poke_req) ram[poke_a] <= poke_d;
    else if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
  end

  acc_core dut (
    .clk(clk), .rst(rst), .instr(instr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .pc(pc)
  );

  function automatic logic [15:0] imm(input logic [14:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [15:0] cmp(input logic a, input logic [5:0] c,
                                      input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_test();
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < 64; i++) rom[i] = '0;
    clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    poke_a = a; poke_d = d; poke_req = 1'b1;
    @(negedge clk) poke_req = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_reset();
    begin_test();
    rom[0] = imm(15'd21);
    rom[1] = cmp(0, K_ONE, 3'b010, 3'b000);
    chk("R1 pc in reset", {1'b0, pc}, 16'd0);
    chk("R1 addr in reset", {1'b0, mem_addr}, 16'd0);
    release_reset();
    step(3);
    chk("R8 pc after 3", {1'b0, pc}, 16'd3);
    rst = 1'b1;
    step(1);
    chk("R1 pc after mid reset", {1'b0, pc}, 16'd0);
    chk("R1 addr after mid reset", {1'b0, mem_addr}, 16'd0);
    rom[0] = cmp(0, K_D, 3'b001, 3'b000);
    release_reset();
    chk("R1 data reg cleared", mem_wdata, 16'd0);
  endtask

  task automatic t_basic();
    begin_test();
    rom[0] = imm(15'd5);
    rom[1] = cmp(0, K_A, 3'b010, 3'b000);
    rom[2] = imm(15'd7);
    rom[3] = cmp(0, K_DPA, 3'b001, 3'b000);
    rom[4] = imm(15'd100);
    rom[5] = cmp(0, K_DM1, 3'b111, 3'b000);
    rom[6] = imm(15'd9);
    rom[7] = {3'b100, 1'b0, K_D, 3'b001, 3'b000};
    release_reset();
    chk("R2 no write on immediate", {15'd0, mem_we}, 16'd0);
    step(1);
    chk("R2 immediate in addr", {1'b0, mem_addr}, 16'd5);
    step(15);
    chk("R8 pc after 16", {1'b0, pc}, 16'd16);
    chk("R6 store D+A", ram[7], 16'd12);
    chk("R9 triple write uses old addr", ram[100], 16'd4);
    chk("R3 ignored bits store", ram[9], 16'd4);
  endtask

  task automatic t_mem_operand();
    begin_test();
    poke(8'd3, 16'd40);
    poke(8'd5, 16'd10);
    rom[0] = imm(15'd3);
    rom[1] = cmp(1, K_A, 3'b010, 3'b000);
    rom[2] = cmp(1, K_AP1, 3'b001, 3'b000);
    rom[3] = imm(15'd5);
    rom[4] = cmp(1, K_DMA, 3'b001, 3'b000);
    rom[5] = imm(15'd4);
    rom[6] = cmp(0, K_D, 3'b001, 3'b000);
    release_reset();
    step(10);
    chk("R4 M+1", ram[3], 16'd41);
    chk("R4 D-M", ram[5], 16'd30);
    chk("R4 D loaded from M", ram[4], 16'd40);
  endtask

  task automatic t_alu();
    begin_test();
    rom[0] = imm(15'd10);      rom[1] = cmp(0, K_ZERO, 3'b001, 3'b000);
    rom[2] = imm(15'd11);      rom[3] = cmp(0, K_ONE, 3'b001, 3'b000);
    rom[4] = imm(15'd12);      rom[5] = cmp(0, K_M1, 3'b001, 3'b000);
    rom[6] = imm(15'h0F0F);    rom[7] = cmp(0, K_A, 3'b010, 3'b000);
    rom[8] = imm(15'd255);     rom[9] = cmp(0, K_AND, 3'b001, 3'b000);
    rom[10] = imm(15'd240);    rom[11] = cmp(0, K_OR, 3'b001, 3'b000);
    rom[12] = imm(15'd14);     rom[13] = cmp(0, K_ND, 3'b001, 3'b000);
    rom[14] = imm(15'd15);     rom[15] = cmp(0, K_AMD, 3'b001, 3'b000);
    rom[16] = imm(15'd16);     rom[17] = cmp(0, K_NEGD, 3'b001, 3'b000);
    rom[18] = imm(15'd18);     rom[19] = cmp(0, K_DP1, 3'b001, 3'b000);
    rom[20] = imm(15'd19);     rom[21] = cmp(0, K_AM1, 3'b001, 3'b000);
    release_reset();
    step(30);
    chk("R5 zero", ram[10], 16'h0000);
    chk("R5 one", ram[11], 16'h0001);
    chk("R5 minus one", ram[12], 16'hFFFF);
    chk("R5 and", ram[255], 16'h000F);
    chk("R5 or", ram[240], 16'h0FFF);
    chk("R5 not D", ram[14], 16'hF0F0);
    chk("R5 A-D", ram[15], 16'hF100);
    chk("R5 neg D", ram[16], 16'hF0F1);
    chk("R5 D+1", ram[18], 16'h0F10);
    chk("R5 A-1", ram[19], 16'h0012);
  endtask

  task automatic t_jump_matrix();
    logic [5:0] src [3];
    logic       neg, zero, pos, taken;
    src[0] = K_M1; src[1] = K_ZERO; src[2] = K_ONE;
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 8; m++) begin
        begin_test();
        rom[0] = cmp(0, src[s], 3'b010, 3'b000);
        rom[1] = imm(15'd10);
        rom[2] = cmp(0, K_D, 3'b000, 3'(m));
        release_reset();
        step(3);
        neg = (s == 0); zero = (s == 1); pos = (s == 2);
        taken = (m[2] && neg) || (m[1] && zero) || (m[0] && pos);
        chk($sformatf("R7 jump mask %0d src %0d", m, s), {1'b0, pc},
            taken ? 16'd10 : 16'd3);
      end
    end
  endtask

  task automatic t_jump_with_a_write();
    begin_test();
    rom[0] = imm(15'd6);
    rom[1] = cmp(0, K_AP1, 3'b100, 3'b111);
    rom[6] = cmp(0, K_A, 3'b001, 3'b000);
    release_reset();
    step(2);
    chk("R9 jump uses old A", {1'b0, pc}, 16'd6);
    chk("R6 A written same cycle", {1'b0, mem_addr}, 16'd7);
    step(1);
    chk("R9 store at new A", ram[7], 16'd7);
  endtask

  task automatic t_pc_wrap();
    begin_test();
    rom[0] = imm(15'h7FFF);
    rom[1] = cmp(0, K_ZERO, 3'b000, 3'b111);
    release_reset();
    step(2);
    chk("R7 jump to top", {1'b0, pc}, 16'h7FFF);
    step(1);
    chk("R8 pc wraps", {1'b0, pc}, 16'd0);
  endtask

  task automatic t_sum_loop();
    begin_test();
    rom[0] = imm(15'd10);  rom[1] = cmp(0, K_A, 3'b010, 3'b000);
    rom[2] = imm(15'd16);  rom[3] = cmp(0, K_D, 3'b001, 3'b000);
    rom[4] = imm(15'd17);  rom[5] = cmp(0, K_ZERO, 3'b001, 3'b000);
    rom[6] = imm(15'd16);  rom[7] = cmp(1, K_A, 3'b010, 3'b000);
    rom[8] = imm(15'd17);  rom[9] = cmp(1, K_DPA, 3'b001, 3'b000);
    rom[10] = imm(15'd16); rom[11] = cmp(1, K_AM1, 3'b011, 3'b000);
    rom[12] = imm(15'd6);  rom[13] = cmp(0, K_D, 3'b000, 3'b001);
    rom[14] = imm(15'd14); rom[15] = cmp(0, K_ZERO, 3'b000, 3'b111);
    release_reset();
    step(200);
    chk("R10 sum", ram[17], 16'd55);
    chk("R10 counter", ram[16], 16'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mem_operand();
    t_alu();
    t_jump_matrix();
    t_jump_with_a_write();
    t_pc_wrap();
    t_sum_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule